// File: doc/BRIEF.md
# EEPROM and PHY Indirect Access Controller

This block lets a host processor reach two slow serial devices through four byte-wide registers: a serial configuration EEPROM on a Microwire-style four-wire bus, and the management registers of an Ethernet PHY on a two-wire MDC/MDIO bus. The host loads a target address and, for writes, a 16-bit data word. It then sets a command bit in the control register. The block runs the serial frame for the selected target and shows a busy flag until the frame is done. For reads, the 16 received bits are placed in the data registers.

A single set of address, data and command registers serves both targets, and one control bit picks between them. A transaction starts on the 0-to-1 edge of a command bit. The hardware never clears a command bit: the host clears it after busy falls, and must do so before it can issue the next command of the same kind. EEPROM writes are allowed only while a write-enable bit is set. A reload bit is passed straight to the surrounding logic as a reload request, and the host clears it when the reload is done.

Both serial clocks come from the system clock through a fixed divider. Each half period of the serial clock is `CLK_DIV` system clocks.

Top module: `eeprom_phy_acc`

## Requirements
- R1: After reset, all four registers read zero, busy is 0, and mdc_o, mdio_oe_o, ee_cs_o and ee_sk_o are low. These outputs stay low whenever busy is 0.
- R2: Register map by reg_sel_i: 0 is control, 1 is address, 2 is data bits 7:0, 3 is data bits 15:8. Control bits are: [0] busy (read only), [1] write command, [2] read command, [3] target (0 selects the EEPROM, 1 selects the PHY), [4] EEPROM write enable, [5] reload. Control bits [7:6] always read 0. The address and data registers read back what was last written to them.
- R3: A control write that takes the read or write command bit from 0 to 1 while the block is idle sets busy from the next cycle. Command bits keep their value until the host writes the control register again.
- R4: A PHY read sends 64 MDC cycles, with mdio_o valid on each rising edge. The frame is 32 ones, start 01, opcode 10, PHY address {000, addr[7:6]} and register number addr[4:0]. The pin is released (mdio_oe_o low) for the last 18 bits. The last 16 bits sampled from mdio_i, MSB first, are stored in the data registers.
- R5: A PHY write drives all 64 bits. The frame is 32 ones, 01, opcode 01, the PHY address, the register number, turnaround 10, and then data bits 15:0, MSB first.
- R6: An EEPROM read raises ee_cs_o for 25 ee_sk_o cycles. It sends start bit 1, opcode 10 and addr[5:0] on ee_di_o. The last 16 bits sampled from ee_do_i, MSB first, are stored in the data registers.
- R7: An EEPROM write sends 1, opcode 01, addr[5:0] and data bits 15:0 over 25 ee_sk_o cycles. It then drops ee_cs_o, raises it again, and keeps busy set until ee_do_i is seen high. At that point ee_cs_o falls and busy clears.
- R8: An EEPROM write command issued with write enable clear is ignored: busy stays 0 and no ee_sk_o or ee_cs_o activity occurs.
- R9: Each serial clock half period lasts CLK_DIV system clocks.
- R10: Only the selected bus is active: no MDC edges and no MDIO drive during EEPROM access, and no chip select or ee_sk_o during PHY access.
- R11: reload_o follows control bit 5.
- R12: Command edges that arrive while busy are ignored. The running frame completes unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock to PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data into EEPROM |
| ee_do_i | input | 1 | Serial data from EEPROM, also ready status |
| reload_o | output | 1 | EEPROM reload request |

## Verification
The properties assume the host follows the command protocol. It sets one command bit per control write, and it does not change the target bit while busy. They also assume the serial devices change their data outputs only after a rising serial-clock edge. The bench models the PHY and the EEPROM so that they update mdio_i and ee_do_i just after each rising MDC or SK edge. It clears each command bit only after busy has fallen, except in the deliberate busy-time edge test. It sweeps every PHY address, a spread of register numbers, and every EEPROM word address, with data values computed from the address.

// File: rtl/eepm_pkg.sv
package eepm_pkg;
  localparam int FRAME_W = 64;
  localparam int DATA_W  = 16;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int MD_LEN  = 64;
  localparam int MD_HDR  = 46;
  localparam int UW_LEN  = 25;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_POLL} seq_e;

  function automatic logic [FRAME_W-1:0] md_frame(input logic rd, input logic [1:0] phy,
                                                  input logic [4:0] rg, input logic [DATA_W-1:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 3'b000, phy, rg,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b0}} : d)};
  endfunction

  function automatic logic [FRAME_W-1:0] md_oe(input logic rd);
    return rd ? {{MD_HDR{1'b1}}, {(FRAME_W-MD_HDR){1'b0}}} : {FRAME_W{1'b1}};
  endfunction

  function automatic logic [FRAME_W-1:0] uw_frame(input logic rd, input logic [5:0] a,
                                                  input logic [DATA_W-1:0] d);
    return {1'b1, (rd ? 2'b10 : 2'b01), a, d, {(FRAME_W-UW_LEN){1'b0}}};
  endfunction
endpackage

// File: rtl/eepm_tick_gen.sv
module eepm_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || !en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)           cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/eepm_shift_eng.sv
module eepm_shift_eng #(
  parameter int W    = 64,
  parameter int RX_W = 16,
  parameter int LW   = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [W-1:0]  frame_i,
  input  logic [W-1:0]  oe_mask_i,
  input  logic          din_i,
  output logic          sclk_o,
  output logic          dout_o,
  output logic          oe_o,
  output logic [RX_W-1:0] rx_o,
  output logic          done_o
);
  logic [W-1:0]    sh_q, msk_q;
  logic [LW-1:0]   left_q;
  logic            phase_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; msk_q <= '0; left_q <= '0; phase_q <= 1'b0; active_q <= 1'b0;
      sclk_o <= 1'b0; dout_o <= 1'b0; oe_o <= 1'b0; rx_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        sh_q <= frame_i; msk_q <= oe_mask_i; left_q <= len_i;
        phase_q <= 1'b0; active_q <= 1'b1; sclk_o <= 1'b0;
      end else if (active_q && tick_i) begin
        if (left_q == '0) begin
          // trailing half period returns clock low
          sclk_o <= 1'b0; oe_o <= 1'b0; active_q <= 1'b0; done_o <= 1'b1;
        end else if (!phase_q) begin
          sclk_o <= 1'b0; dout_o <= sh_q[W-1]; oe_o <= msk_q[W-1]; phase_q <= 1'b1;
        end else begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[RX_W-2:0], din_i};
          sh_q   <= {sh_q[W-2:0], 1'b0};
          msk_q  <= {msk_q[W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eepm_host_regs.sv
module eepm_host_regs #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          busy_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  output logic          start_o,
  output logic          start_rd_o,
  output logic          start_phy_o,
  output logic [7:0]    addr_o,
  output logic [DW-1:0] data_o,
  output logic          rd_cmd_o,
  output logic          wr_cmd_o,
  output logic          reload_o
);
  logic rd_q, wr_q, tgt_q, wen_q, rel_q;
  logic ctrl_wr, rd_rise, wr_rise;

  assign ctrl_wr = we_i && (sel_i == 2'd0);
  assign rd_rise = ctrl_wr && wdata_i[2] && !rd_q;
  assign wr_rise = ctrl_wr && wdata_i[1] && !wr_q;
  // read wins if both edges arrive together; EEPROM write needs enable
  assign start_o     = !busy_i && (rd_rise || (wr_rise && (wdata_i[3] || wdata_i[4])));
  assign start_rd_o  = rd_rise;
  assign start_phy_o = wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0; wr_q <= 1'b0; tgt_q <= 1'b0; wen_q <= 1'b0; rel_q <= 1'b0;
      addr_o <= '0; data_o <= '0;
    end else begin
      if (ctrl_wr) begin
        wr_q <= wdata_i[1]; rd_q <= wdata_i[2]; tgt_q <= wdata_i[3];
        wen_q <= wdata_i[4]; rel_q <= wdata_i[5];
      end
      if (we_i && sel_i == 2'd1) addr_o <= wdata_i;
      if (load_i) data_o <= load_data_i;
      else begin
        if (we_i && sel_i == 2'd2) data_o[7:0]    <= wdata_i;
        if (we_i && sel_i == 2'd3) data_o[DW-1:8] <= wdata_i[DW-9:0];
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      2'd0:    rdata_o = {2'b00, rel_q, wen_q, tgt_q, rd_q, wr_q, busy_i};
      2'd1:    rdata_o = addr_o;
      2'd2:    rdata_o = data_o[7:0];
      default: rdata_o = data_o[DW-1:8];
    endcase
  end

  assign rd_cmd_o = rd_q;
  assign wr_cmd_o = wr_q;
  assign reload_o = rel_q;
endmodule

// File: rtl/eeprom_phy_acc.sv
module eeprom_phy_acc
  import eepm_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       mdc_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic       mdio_i,
  output logic       ee_cs_o,
  output logic       ee_sk_o,
  output logic       ee_di_o,
  input  logic       ee_do_i,
  output logic       reload_o
);
  seq_e              state_q;
  logic              busy_q, tgt_phy_q, op_rd_q, cs_q;
  logic              start_w, start_rd_w, start_phy_w, tick_w;
  logic              rd_cmd_w, wr_cmd_w, load_w;
  logic [7:0]        addr_w;
  logic [DATA_W-1:0] data_w, rx_w;
  logic [FRAME_W-1:0] frame_w, oe_mask_w;
  logic [LEN_W-1:0]  len_w;
  logic              sclk_w, dout_w, oe_w, eng_done_w;

  eepm_host_regs #(.DW(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_q), .load_i(load_w), .load_data_i(rx_w),
    .start_o(start_w), .start_rd_o(start_rd_w), .start_phy_o(start_phy_w),
    .addr_o(addr_w), .data_o(data_w),
    .rd_cmd_o(rd_cmd_w), .wr_cmd_o(wr_cmd_w), .reload_o(reload_o)
  );

  eepm_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(start_w), .en_i(busy_q), .tick_o(tick_w)
  );

  always_comb begin
    if (start_phy_w) begin
      frame_w   = md_frame(start_rd_w, addr_w[7:6], addr_w[4:0], data_w);
      oe_mask_w = md_oe(start_rd_w);
      len_w     = LEN_W'(MD_LEN);
    end else begin
      frame_w   = uw_frame(start_rd_w, addr_w[5:0], data_w);
      oe_mask_w = {FRAME_W{1'b1}};
      len_w     = LEN_W'(UW_LEN);
    end
  end

  eepm_shift_eng #(.W(FRAME_W), .RX_W(DATA_W), .LW(LEN_W)) u_eng (
    .clk_i, .rst_ni, .tick_i(tick_w), .start_i(start_w), .len_i(len_w),
    .frame_i(frame_w), .oe_mask_i(oe_mask_w),
    .din_i(tgt_phy_q ? mdio_i : ee_do_i),
    .sclk_o(sclk_w), .dout_o(dout_w), .oe_o(oe_w), .rx_o(rx_w), .done_o(eng_done_w)
  );

  assign load_w = (state_q == ST_SHIFT) && eng_done_w && op_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; busy_q <= 1'b0; tgt_phy_q <= 1'b0; op_rd_q <= 1'b0; cs_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_w) begin
          busy_q <= 1'b1; tgt_phy_q <= start_phy_w; op_rd_q <= start_rd_w;
          cs_q <= !start_phy_w; state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (eng_done_w) begin
          cs_q <= 1'b0;
          if (tgt_phy_q || op_rd_q) begin
            busy_q <= 1'b0; state_q <= ST_IDLE;
          end else begin
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (tick_w) begin
          cs_q <= 1'b1; state_q <= ST_POLL;
        end
        ST_POLL: if (tick_w && ee_do_i) begin
          cs_q <= 1'b0; busy_q <= 1'b0; state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mdc_o     = tgt_phy_q & sclk_w;
  assign mdio_o    = tgt_phy_q & dout_w;
  assign mdio_oe_o = tgt_phy_q & oe_w;
  assign ee_cs_o   = cs_q;
  assign ee_sk_o   = !tgt_phy_q & sclk_w;
  assign ee_di_o   = !tgt_phy_q & cs_q & dout_w;
endmodule

// File: rtl/eeprom_phy_acc_chk.sv
module eeprom_phy_acc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_sel_i,
  input logic [7:0] reg_wdata_i,
  input logic       busy_i,
  input logic       rd_cmd_i,
  input logic       wr_cmd_i,
  input logic       mdc_i,
  input logic       mdio_oe_i,
  input logic       ee_cs_i,
  input logic       ee_sk_i
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_sel_i == 2'd0);

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i && !ee_cs_i && !ee_sk_i));

  // R3
  a_r3_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[2] && !rd_cmd_i && !busy_i) |=> busy_i);

  // R3
  a_r3_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> ($stable(rd_cmd_i) && $stable(wr_cmd_i)));

  // R8
  a_r8_we_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[1] && !reg_wdata_i[2] && !reg_wdata_i[3] && !reg_wdata_i[4]
     && !busy_i) |=> !busy_i);

  // R10
  a_r10_one_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ee_cs_i && (mdc_i || mdio_oe_i)) && !(ee_sk_i && mdc_i));
endmodule

bind eeprom_phy_acc eeprom_phy_acc_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .reg_wdata_i(reg_wdata_i), .busy_i(busy_q), .rd_cmd_i(rd_cmd_w), .wr_cmd_i(wr_cmd_w),
  .mdc_i(mdc_o), .mdio_oe_i(mdio_oe_o), .ee_cs_i(ee_cs_o), .ee_sk_i(ee_sk_o)
);

// File: tb/eeprom_phy_acc_tb_top.sv
module eeprom_phy_acc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i = 1'b1;
  logic ee_cs, ee_sk, ee_di, ee_do = 1'b0, reload;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_phy_acc #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i),
    .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do), .reload_o(reload)
  );

  // PHY model
  int md_n = 0, md_rises = 0;
  logic [63:0] md_cap, md_oev;
  logic [15:0] md_data;
  time md_t0, md_t1;
  always @(posedge mdc) begin
    if (md_n < 64) begin
      md_cap[63-md_n] = mdio_o;
      md_oev[63-md_n] = mdio_oe;
    end
    md_n++; md_rises++;
    md_t0 = md_t1; md_t1 = $time;
    mdio_i = (md_n >= 48 && md_n < 64) ? md_data[63-md_n] : 1'b1;
  end

  // EEPROM model
  int ee_n = 0, sk_total = 0, cs_rises = 0;
  logic [24:0] ee_cap;
  logic [15:0] ee_data;
  time sk_t0, sk_t1;
  always @(posedge ee_cs) begin
    ee_n = 0; cs_rises++; ee_do = 1'b0;
  end
  always @(posedge ee_sk) begin
    if (ee_n < 25) ee_cap[24-ee_n] = ee_di;
    ee_n++; sk_total++;
    sk_t0 = sk_t1; sk_t1 = $time;
    ee_do = (ee_n >= 9 && ee_n < 25) ? ee_data[24-ee_n] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(2'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic phy_txn(input bit rd, input logic [1:0] phy, input logic [4:0] rg,
                         input logic [15:0] d);
    logic [7:0] v, lo, hi;
    logic [63:0] exp_f, exp_oe;
    int sk0;
    md_n = 0; md_data = d; mdio_i = 1'b1; sk0 = sk_total;
    if (!rd) begin reg_wr(2'd2, d[7:0]); reg_wr(2'd3, d[15:8]); end
    reg_wr(2'd1, {phy, 1'b0, rg});
    reg_wr(2'd0, rd ? 8'h0C : 8'h0A);
    reg_rd(2'd0, v);
    chk(v[0] == 1'b1, "R3 busy rise", {63'd0, v[0]}, 64'd1);
    wait_idle();
    exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 3'b000, phy, rg,
              (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : d)};
    exp_oe = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    chk(md_n == 64, rd ? "R4 bit count" : "R5 bit count", 64'(md_n), 64'd64);
    chk(md_oev == exp_oe, rd ? "R4 drive window" : "R5 drive window", md_oev, exp_oe);
    chk((md_cap & exp_oe) == (exp_f & exp_oe), rd ? "R4 frame" : "R5 frame", md_cap, exp_f);
    chk(sk_total == sk0 && !ee_cs, "R10 eeprom quiet", 64'(sk_total - sk0), 64'd0);
    if (rd) begin
      reg_rd(2'd2, lo); reg_rd(2'd3, hi);
      chk({hi, lo} == d, "R4 read data", {48'd0, hi, lo}, {48'd0, d});
    end
    reg_rd(2'd0, v);
    chk(v[2:1] == (rd ? 2'b10 : 2'b01), "R3 command held", {62'd0, v[2:1]},
        {62'd0, (rd ? 2'b10 : 2'b01)});
    reg_wr(2'd0, 8'h08);
  endtask

  task automatic ee_read(input logic [5:0] a, input logic [15:0] d);
    logic [7:0] lo, hi;
    int sk0, md0;
    ee_data = d; sk0 = sk_total; md0 = md_rises;
    reg_wr(2'd1, {2'b00, a});
    reg_wr(2'd0, 8'h04);
    wait_idle();
    chk(sk_total - sk0 == 25, "R6 bit count", 64'(sk_total - sk0), 64'd25);
    chk(ee_cap[24:16] == {3'b110, a}, "R6 command bits", {55'd0, ee_cap[24:16]},
        {55'd0, 3'b110, a});
    reg_rd(2'd2, lo); reg_rd(2'd3, hi);
    chk({hi, lo} == d, "R6 read data", {48'd0, hi, lo}, {48'd0, d});
    chk(md_rises == md0 && !ee_cs, "R10 mdc quiet", 64'(md_rises - md0), 64'd0);
    reg_wr(2'd0, 8'h00);
  endtask

  task automatic ee_write(input logic [5:0] a, input logic [15:0] d);
    logic [7:0] v;
    int sk0, cs0;
    sk0 = sk_total; cs0 = cs_rises;
    reg_wr(2'd2, d[7:0]); reg_wr(2'd3, d[15:8]);
    reg_wr(2'd1, {2'b00, a});
    reg_wr(2'd0, 8'h12);
    for (int i = 0; i < 2000 && cs_rises < cs0 + 2; i++) @(negedge clk);
    chk(cs_rises == cs0 + 2, "R7 chip select reopened", 64'(cs_rises - cs0), 64'd2);
    repeat (20) @(negedge clk);
    reg_rd(2'd0, v);
    chk(v[0] && ee_cs, "R7 busy while not ready", {62'd0, v[0], ee_cs}, 64'd3);
    ee_do = 1'b1;
    wait_idle();
    chk(!ee_cs, "R7 chip select released", {63'd0, ee_cs}, 64'd0);
    chk(sk_total - sk0 == 25, "R7 bit count", 64'(sk_total - sk0), 64'd25);
    chk(ee_cap == {3'b101, a, d}, "R7 frame", {39'd0, ee_cap}, {39'd0, 3'b101, a, d});
    ee_do = 1'b0;
    reg_wr(2'd0, 8'h10);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_rd(2'(s), v);
      chk(v == 8'h00, "R1 reset register", {56'd0, v}, 64'd0);
    end
    chk(!mdc && !mdio_oe && !ee_cs && !ee_sk && !reload, "R1 idle outputs",
        {59'd0, mdc, mdio_oe, ee_cs, ee_sk, reload}, 64'd0);

    // R2 readback, R11 reload
    reg_wr(2'd1, 8'hC7); reg_rd(2'd1, v);
    chk(v == 8'hC7, "R2 address readback", {56'd0, v}, 64'hC7);
    reg_wr(2'd2, 8'h3A); reg_rd(2'd2, v);
    chk(v == 8'h3A, "R2 data low readback", {56'd0, v}, 64'h3A);
    reg_wr(2'd3, 8'hE1); reg_rd(2'd3, v);
    chk(v == 8'hE1, "R2 data high readback", {56'd0, v}, 64'hE1);
    reg_wr(2'd0, 8'hF8); reg_rd(2'd0, v);
    chk(v == 8'h38, "R2 control readback", {56'd0, v}, 64'h38);
    chk(reload == 1'b1, "R11 reload set", {63'd0, reload}, 64'd1);
    reg_wr(2'd0, 8'h00);
    chk(reload == 1'b0, "R11 reload cleared", {63'd0, reload}, 64'd0);

    // R4/R5 sweep over all PHY addresses
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) begin
        logic [4:0] rg;
        logic [15:0] d;
        rg = 5'((k * 13 + p * 5) % 32);
        d  = 16'hA5C3 ^ 16'(p << 12) ^ 16'(k * 16'h0F1);
        phy_txn(1'b1, 2'(p), rg, d);
        phy_txn(1'b0, 2'(p), rg, ~d);
      end
    end
    // R9 half period
    chk(md_t1 - md_t0 == 2 * CLK_DIV * CLK_PERIOD, "R9 mdc period", 64'(md_t1 - md_t0),
        64'(2 * CLK_DIV * CLK_PERIOD));

    // R12 edges while busy
    md_n = 0; md_data = 16'h1234;
    reg_wr(2'd1, 8'h41);
    reg_wr(2'd0, 8'h0C);
    repeat (20) @(negedge clk);
    reg_wr(2'd0, 8'h08);
    reg_wr(2'd0, 8'h0C);
    wait_idle();
    chk(md_n == 64, "R12 frame length unchanged", 64'(md_n), 64'd64);
    repeat (100) @(negedge clk);
    reg_rd(2'd0, v);
    chk(!v[0] && md_n == 64, "R12 no restart", 64'(md_n), 64'd64);
    reg_wr(2'd0, 8'h00);

    // R6 every EEPROM word address
    for (int a = 0; a < 64; a++) ee_read(6'(a), 16'(a * 16'h1357) ^ 16'hC0DE);
    chk(sk_t1 - sk_t0 == 2 * CLK_DIV * CLK_PERIOD, "R9 sk period", 64'(sk_t1 - sk_t0),
        64'(2 * CLK_DIV * CLK_PERIOD));

    // R8 write without enable
    begin
      int sk0, cs0;
      sk0 = sk_total; cs0 = cs_rises;
      reg_wr(2'd0, 8'h02);
      reg_rd(2'd0, v);
      chk(!v[0], "R8 busy stays low", {63'd0, v[0]}, 64'd0);
      repeat (60) @(negedge clk);
      reg_rd(2'd0, v);
      chk(!v[0] && sk_total == sk0 && cs_rises == cs0, "R8 no bus activity",
          64'(sk_total - sk0 + cs_rises - cs0), 64'd0);
      reg_wr(2'd0, 8'h00);
    end

    // R7 writes
    ee_write(6'h00, 16'hBEEF);
    ee_write(6'h2A, 16'h0001);
    ee_write(6'h3F, 16'h8000);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule